// File: doc/BRIEF.md
# Pipeline Special-Instruction Hold Controller

This block drives the stage-register enables and flush controls of a five-stage in-order pipeline whose branches resolve in the MEM stage. Besides the usual data-cache-miss freeze, the taken-branch flush and the load-use stall requested by the hazard detector, it supports one unusual instruction: a special opcode whose decoded controls are all zero, so it behaves as a bubble downstream. Once this opcode is latched into the ID/EX register, it parks there. The ID/EX register is kept disabled, so the all-zero controls keep flowing into MEM and WB. Every instruction that reaches ID in the meantime is discarded.

The park ends in one of two ways. The first is a valid instruction with its branch flag set reaching ID. That branch is admitted into EX in the same edge and overwrites the special instruction, and normal flow resumes from it. The second is a taken branch that is older than the special instruction. Its flush removes the special instruction whether it sits in IF, ID or EX. A single flag flip-flop beside ID/EX remembers that the special instruction is parked and is visible as `sink_active`. The outputs are combinational from the current inputs and that flag, so they act in the same cycle.

Top module: `spc_hold_ctrl`

## Requirements
- R1: While `rst` is 1 the block drives `stage_en` = 5'b00000 and `flush` = 3'b111, and `sink_active` is 0 in the cycle after any reset cycle. Bit map of `stage_en`: bit0 PC, bit1 IF/ID, bit2 ID/EX, bit3 EX/MEM, bit4 MEM/WB. Bit map of `flush`: bit0 bubble into IF/ID, bit1 bubble into ID/EX, bit2 bubble into EX/MEM.
- R2: With no other condition active, `stage_en` = 5'b11111 and `flush` = 3'b000. A valid special opcode in ID that advances in such a cycle makes `sink_active` 1 from the next cycle on.
- R3: While `sink_active` is 1 and ID holds no valid branch, the outputs are `stage_en` = 5'b11011 and `flush` = 3'b010. ID/EX stays closed and the instruction in ID is discarded. `sink_active` stays 1.
- R4: The park of R3 takes precedence over a hazard-detector stall request.
- R5: While `sink_active` is 1, a valid instruction with its branch flag set in ID gives `stage_en` = 5'b11111 and `flush` = 3'b000, and `sink_active` is 0 in the next cycle. An invalid slot with the branch flag set does not release the park.
- R6: A data-cache miss gives `stage_en` = 5'b00000 and `flush` = 3'b000, and leaves `sink_active` unchanged. It outranks every condition except reset.
- R7: A taken branch in MEM gives `stage_en` = 5'b11111 and `flush` = 3'b111, and clears `sink_active` for the next cycle. It outranks release, park and the hazard stall.
- R8: A special opcode in ID in the same cycle as a taken-branch flush is not parked: `sink_active` stays 0.
- R9: A hazard-detector stall, with nothing of higher rank active, gives `stage_en` = 5'b11100 and `flush` = 3'b010.
- R10: A special opcode held in ID by a hazard stall is not parked in that cycle. It is parked in the later cycle in which it advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | ID stage holds a real instruction |
| id_special | input | 1 | Instruction in ID carries the special opcode |
| id_branch | input | 1 | Branch control flag of the instruction in ID |
| mem_br_taken | input | 1 | Branch in MEM resolved taken |
| hdu_stall | input | 1 | Hazard detector requests a load-use stall |
| dcache_miss | input | 1 | Data cache miss in MEM, freeze pipeline |
| stage_en | output | 5 | Stage register enables (PC, IF/ID, ID/EX, EX/MEM, MEM/WB) |
| flush | output | 3 | Bubble insertion into IF/ID, ID/EX, EX/MEM |
| sink_active | output | 1 | Special instruction is parked in EX |

## Verification
The hardest situations to reach are the collisions on the park flag. One is a taken branch or a cache miss arriving while the special instruction is parked. Another is a branch in ID that would release it, arriving in the same cycle as a higher-ranked freeze. A third is a special opcode reaching ID in the same cycle as a flush or hazard stall. The bench first parks the special instruction, so the flag is set. It then drives these combinations cycle by cycle, and after each one checks both the output vectors and whether the flag survived into the following cycle.

// File: rtl/spc_hold_pkg.sv
package spc_hold_pkg;
  localparam int unsigned N_EN = 5;
  localparam int unsigned N_FL = 3;

  typedef enum logic [2:0] {
    M_RESET   = 3'd0,
    M_MISS    = 3'd1,
    M_FLUSH   = 3'd2,
    M_RELEASE = 3'd3,
    M_PARK    = 3'd4,
    M_HDU     = 3'd5,
    M_RUN     = 3'd6
  } ctl_mode_e;

  typedef struct packed {
    logic [N_EN-1:0] en;
    logic [N_FL-1:0] fl;
  } ctl_vec_t;
endpackage

// File: rtl/spc_mode_arb.sv
module spc_mode_arb
  import spc_hold_pkg::*;
(
  input  logic      rst,
  input  logic      sink,
  input  logic      id_valid,
  input  logic      id_branch,
  input  logic      mem_br_taken,
  input  logic      hdu_stall,
  input  logic      dcache_miss,
  output ctl_mode_e mode
);
  logic branch_in_id;
  assign branch_in_id = id_valid & id_branch;

  always_comb begin
    if (rst)                       mode = M_RESET;
    else if (dcache_miss)          mode = M_MISS;
    else if (mem_br_taken)         mode = M_FLUSH;
    else if (sink && branch_in_id) mode = M_RELEASE;
    else if (sink)                 mode = M_PARK;
    else if (hdu_stall)            mode = M_HDU;
    else                           mode = M_RUN;
  end
endmodule

// File: rtl/spc_ctl_enc.sv
module spc_ctl_enc
  import spc_hold_pkg::*;
(
  input  ctl_mode_e mode,
  output ctl_vec_t  vec
);
  always_comb begin
    vec = '{en: '1, fl: '0};
    case (mode)
      M_RESET: vec = '{en: '0, fl: '1};
      M_MISS:  vec = '{en: '0, fl: '0};
      M_FLUSH: vec = '{en: '1, fl: '1};
      M_PARK:  vec = '{en: 5'b11011, fl: 3'b010};
      M_HDU:   vec = '{en: 5'b11100, fl: 3'b010};
      default: vec = '{en: '1, fl: '0};
    endcase
  end
endmodule

// File: rtl/spc_sink_track.sv
module spc_sink_track
  import spc_hold_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  ctl_mode_e mode,
  input  logic      id_valid,
  input  logic      id_special,
  output logic      sink
);
  logic sink_nxt;

  always_comb begin
    case (mode)
      M_RESET, M_FLUSH, M_RELEASE: sink_nxt = 1'b0;
      M_MISS, M_PARK:              sink_nxt = sink;
      M_HDU:                       sink_nxt = 1'b0;
      default:                     sink_nxt = id_valid & id_special;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) sink <= 1'b0;
    else     sink <= sink_nxt;
  end

  p_sink_clears_after_release_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == M_RELEASE) |=> !sink);
  p_sink_stable_on_miss_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == M_MISS) |=> $stable(sink));
  p_flush_clears_sink_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == M_FLUSH) |=> !sink);
endmodule

// File: rtl/spc_hold_ctrl.sv
module spc_hold_ctrl
  import spc_hold_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            id_valid,
  input  logic            id_special,
  input  logic            id_branch,
  input  logic            mem_br_taken,
  input  logic            hdu_stall,
  input  logic            dcache_miss,
  output logic [N_EN-1:0] stage_en,
  output logic [N_FL-1:0] flush,
  output logic            sink_active
);
  ctl_mode_e mode;
  ctl_vec_t  vec;
  logic      sink;

  spc_mode_arb u_arb (
    .rst(rst), .sink(sink), .id_valid(id_valid), .id_branch(id_branch),
    .mem_br_taken(mem_br_taken), .hdu_stall(hdu_stall),
    .dcache_miss(dcache_miss), .mode(mode)
  );

  spc_ctl_enc u_enc (.mode(mode), .vec(vec));

  spc_sink_track u_trk (
    .clk(clk), .rst(rst), .mode(mode), .id_valid(id_valid),
    .id_special(id_special), .sink(sink)
  );

  assign stage_en    = vec.en;
  assign flush       = vec.fl;
  assign sink_active = sink;

  always_comb begin
    if (rst) p_reset_outputs_r1: assert (stage_en == '0 && flush == '1);
  end

  p_reset_clears_sink_r1: assert property (@(posedge clk)
    rst |=> !sink_active);
  p_miss_freezes_all_r6: assert property (@(posedge clk) disable iff (rst)
    dcache_miss |-> (stage_en == '0 && flush == '0));
  p_park_closes_idex_r3: assert property (@(posedge clk) disable iff (rst)
    (sink_active && !dcache_miss && !mem_br_taken && !(id_valid && id_branch))
      |-> (!stage_en[2] && flush[1]));
  p_flush_beats_hdu_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_br_taken && !dcache_miss && hdu_stall) |-> (stage_en == '1 && flush == '1));
  p_taken_blocks_park_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_br_taken && !dcache_miss) |=> !sink_active);
endmodule

// File: tb/sim_spc_hold_ctrl.sv
module sim_spc_hold_ctrl;
  logic clk = 1'b0;
  logic rst, id_valid, id_special, id_branch, mem_br_taken, hdu_stall, dcache_miss;
  logic [4:0] stage_en;
  logic [2:0] flush;
  logic       sink_active;

  int checks = 0;
  int fails  = 0;
  logic model_sink = 1'b0;
  logic [8:0] expq[$];
  string      tagq[$];
  bit done = 1'b0;

  always #5 clk = ~clk;

  spc_hold_ctrl u0 (
    .clk(clk), .rst(rst), .id_valid(id_valid), .id_special(id_special),
    .id_branch(id_branch), .mem_br_taken(mem_br_taken), .hdu_stall(hdu_stall),
    .dcache_miss(dcache_miss), .stage_en(stage_en), .flush(flush),
    .sink_active(sink_active)
  );

  task automatic step(input logic r, v, s, b, t, h, m, input string tag);
    logic [4:0] e;
    logic [2:0] f;
    logic nxt;
    @(negedge clk);
    rst = r; id_valid = v; id_special = s; id_branch = b;
    mem_br_taken = t; hdu_stall = h; dcache_miss = m;
    nxt = model_sink;
    if (r)                        begin e = 5'b00000; f = 3'b111; nxt = 1'b0; end
    else if (m)                   begin e = 5'b00000; f = 3'b000; end
    else if (t)                   begin e = 5'b11111; f = 3'b111; nxt = 1'b0; end
    else if (model_sink && v && b) begin e = 5'b11111; f = 3'b000; nxt = 1'b0; end
    else if (model_sink)          begin e = 5'b11011; f = 3'b010; end
    else if (h)                   begin e = 5'b11100; f = 3'b010; nxt = 1'b0; end
    else                          begin e = 5'b11111; f = 3'b000; nxt = v & s; end
    expq.push_back({e, f, model_sink});
    tagq.push_back(tag);
    model_sink = nxt;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #2;
      if (expq.size() != 0) begin
        logic [8:0] exp_v;
        string tg;
        exp_v = expq.pop_front();
        tg = tagq.pop_front();
        checks++;
        if ({stage_en, flush, sink_active} !== exp_v) begin
          fails++;
          $display("FAIL %s: got en=%b fl=%b sink=%b, expected en=%b fl=%b sink=%b",
                   tg, stage_en, flush, sink_active, exp_v[8:4], exp_v[3:1], exp_v[0]);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    //    r  v  s  b  t  h  m
    step(1, 0, 0, 0, 0, 0, 0, "R1 reset");
    step(1, 1, 1, 0, 0, 0, 0, "R1 reset with special in ID");
    step(0, 0, 0, 0, 0, 0, 0, "R1 sink clear after reset / R2 run");
    step(0, 1, 0, 0, 0, 0, 0, "R2 normal run");
    step(0, 1, 1, 0, 0, 0, 0, "R2 special advances");
    step(0, 1, 0, 0, 0, 0, 0, "R3 park nullify");
    step(0, 1, 0, 0, 0, 1, 0, "R4 park beats hdu");
    step(0, 0, 0, 1, 0, 0, 0, "R5 invalid branch does not release");
    step(0, 1, 0, 1, 0, 0, 0, "R5 branch releases");
    step(0, 1, 0, 0, 0, 0, 0, "R5 sink clear after release");
    step(0, 1, 1, 0, 0, 1, 0, "R10 special under hdu not parked");
    step(0, 1, 1, 0, 0, 0, 0, "R10 special advances later");
    step(0, 1, 0, 1, 0, 0, 1, "R6 miss beats release");
    step(0, 1, 0, 0, 0, 0, 1, "R6 miss keeps sink");
    step(0, 1, 0, 0, 1, 0, 0, "R7 taken flush beats park");
    step(0, 1, 0, 0, 0, 0, 0, "R7 sink clear after flush");
    step(0, 1, 1, 0, 1, 0, 0, "R8 special with taken flush");
    step(0, 1, 0, 0, 0, 0, 0, "R8 not parked");
    step(0, 1, 0, 0, 0, 1, 0, "R9 hdu stall");
    step(0, 1, 0, 0, 1, 1, 0, "R7 flush beats hdu");
    step(0, 1, 0, 0, 1, 1, 1, "R6 miss beats flush and hdu");
    step(0, 1, 1, 0, 0, 0, 0, "R2 park again");
    step(0, 1, 1, 1, 0, 0, 0, "R5 release by branch");
    step(0, 1, 1, 0, 0, 0, 0, "R2 park third time");
    step(1, 0, 0, 0, 0, 0, 0, "R1 reset during park");
    step(0, 0, 0, 0, 0, 0, 0, "R1 sink clear after reset");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule